// File: doc/BRIEF.md
# Loudest-Talker Conference Selector

This block picks who speaks in a multi-party voice conference, one frame at a time. On each frame strobe it takes one 16-bit signed linear sample per time slot, together with a mask of the slots that belong to the conference. During the following frame interval it walks the member slots once, comparing absolute values. It keeps the largest and the second-largest magnitude found so far, so one pass yields both.

The outgoing frame goes back to the members. The loudest member hears the runner-up's sample, and every other member hears the loudest member's sample. Each listener therefore gets exactly one voice, and nobody hears their own. Slots outside the conference get silence. The chosen slot numbers are also brought out, so the selection can be observed.

Latency is one strobe. A frame latched at strobe M is ranked before the next strobe arrives. Its routed result appears right after strobe M+1 and is held for the whole following frame interval.

Top module: `conf_talker_select`

## Requirements
- R1: Members are ranked by the absolute value of their signed sample, so a negative sample of larger magnitude outranks a smaller positive one.
- R2: The magnitude of the most negative sample value (-32768) saturates to 32767, so it ties with +32767.
- R3: In the routed frame, the loudest member's slot carries the runner-up's original signed sample, and every other member slot carries the loudest member's original signed sample.
- R4: Slots whose mask bit is 0 take no part in the ranking, whatever their sample, and their output slot is 0.
- R5: When magnitudes are equal, the lower slot index ranks higher. This applies to both first and second place.
- R6: With exactly one member, that member's output slot is 0, `sel_first` names it and `sel_second_vld` is 0.
- R7: With no members, every output slot is 0 and `sel_first`, `sel_second` and `sel_second_vld` keep their earlier values.
- R8: The frame latched at one strobe is routed on the clock edge of the next strobe. `out_vld` is high for exactly the one cycle after that edge, and `out_frame` and the selection outputs hold their values between strobes.
- R9: After reset, `out_frame`, `out_vld`, `sel_first`, `sel_second` and `sel_second_vld` are all 0. The first strobe after reset produces no `out_vld` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_frame | input | NSLOT*SW | Slot samples; slot s occupies bits s*SW+SW-1 down to s*SW, two's complement |
| in_mask | input | NSLOT | Bit s set means slot s is a conference member |
| in_frame_vld | input | 1 | One-cycle strobe that latches in_frame and in_mask |
| out_frame | output | NSLOT*SW | Routed frame, same slot layout as in_frame |
| out_vld | output | 1 | One-cycle pulse when out_frame is updated |
| sel_first | output | $clog2(NSLOT) | Slot index of the loudest member of the last ranked frame that had members |
| sel_second | output | $clog2(NSLOT) | Slot index of the runner-up (0 when there is none) |
| sel_second_vld | output | 1 | A runner-up existed in that frame |

## Verification
The assertions assume the input side keeps its strobe spacing. Two strobes must be at least NSLOT+1 clock cycles apart, so the single-pass ranking finishes before its result is needed. One assertion counts that gap against the inputs. The bench leaves NSLOT+4 cycles between strobes and always holds the strobe for exactly one cycle. Under that spacing, the slot-source assertion may compare each routed slot against a frame the checker captured on its own two strobes earlier.

// File: rtl/conf_sel_pkg.sv
// Shared definitions for the conference talker selector.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package conf_sel_pkg;

    // Phase of the single-pass ranking walk.
    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_RUN  = 2'd1,
        SCAN_DONE = 2'd2
    } scan_state_e;

endpackage

// File: rtl/conf_mag_abs.sv
// Absolute value of a signed sample, saturating the most negative code.
// Assumes: SW >= 2; output is unsigned and at most 2**(SW-1)-1.
module conf_mag_abs #(
    parameter int SW = 16
) (
    input  logic [SW-1:0] sample,
    output logic [SW-1:0] mag
);

    localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};
    localparam logic [SW-1:0] MAG_MAX  = {1'b0, {(SW-1){1'b1}}};

    // Fold negative samples; clamp the one value whose negation overflows.
    always_comb begin
        if (sample == MOST_NEG) begin
            mag = MAG_MAX;
        end else if (sample[SW-1]) begin
            mag = (~sample) + 1'b1;
        end else begin
            mag = sample;
        end
    end

endmodule

// File: rtl/conf_rank_scan.sv
// Single-pass top-two ranking over the member slots of a latched frame.
// Visits one slot per clock in ascending order after 'start'; a strictly
// greater magnitude is needed to displace a holder, so lower slots win ties.
// Assumes: frame_flat and mask stay stable for NSLOT cycles after start.
module conf_rank_scan
    import conf_sel_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int SW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NSLOT*SW-1:0] frame_flat,
    input  logic [NSLOT-1:0]    mask,
    output logic [$clog2(NSLOT)-1:0] best_idx,
    output logic                best_vld,
    output logic [$clog2(NSLOT)-1:0] sec_idx,
    output logic                sec_vld,
    output logic                done
);

    localparam int IW = $clog2(NSLOT);
    localparam logic [IW-1:0] LAST_IDX = IW'(NSLOT - 1);

    scan_state_e   state;
    logic [IW-1:0] cur_idx;
    logic [SW-1:0] cur_sample;
    logic [SW-1:0] cur_mag;
    logic [SW-1:0] best_mag;
    logic [SW-1:0] sec_mag;
    logic          cur_member;
    logic          beats_best;
    logic          beats_sec;

    // Pick the slot under inspection.
    always_comb begin
        cur_sample = frame_flat[cur_idx*SW +: SW];
        cur_member = mask[cur_idx];
    end

    conf_mag_abs #(.SW(SW)) u_mag (
        .sample (cur_sample),
        .mag    (cur_mag)
    );

    // Compare against the two current holders.
    always_comb begin
        beats_best = !best_vld || (cur_mag > best_mag);
        beats_sec  = !sec_vld  || (cur_mag > sec_mag);
    end

    // Walk the slots and keep the two largest magnitudes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SCAN_IDLE;
            cur_idx  <= '0;
            best_idx <= '0;
            best_vld <= 1'b0;
            best_mag <= '0;
            sec_idx  <= '0;
            sec_vld  <= 1'b0;
            sec_mag  <= '0;
        end else if (start) begin
            state    <= SCAN_RUN;
            cur_idx  <= '0;
            best_vld <= 1'b0;
            sec_vld  <= 1'b0;
            best_idx <= '0;
            sec_idx  <= '0;
            best_mag <= '0;
            sec_mag  <= '0;
        end else if (state == SCAN_RUN) begin
            if (cur_member) begin
                if (beats_best) begin
                    sec_idx  <= best_idx;
                    sec_mag  <= best_mag;
                    sec_vld  <= best_vld;
                    best_idx <= cur_idx;
                    best_mag <= cur_mag;
                    best_vld <= 1'b1;
                end else if (beats_sec) begin
                    sec_idx <= cur_idx;
                    sec_mag <= cur_mag;
                    sec_vld <= 1'b1;
                end
            end
            if (cur_idx == LAST_IDX) begin
                state <= SCAN_DONE;
            end else begin
                cur_idx <= cur_idx + 1'b1;
            end
        end
    end

    assign done = (state == SCAN_DONE);

endmodule

// File: rtl/conf_frame_route.sv
// Builds the outgoing frame from the ranking of a latched frame.
// Loudest member gets the runner-up's sample, other members get the
// loudest sample, non-members get zero.
// Assumes: best_idx/sec_idx name member slots when their valid bits are set.
module conf_frame_route #(
    parameter int NSLOT = 32,
    parameter int SW    = 16
) (
    input  logic [NSLOT*SW-1:0]      frame_flat,
    input  logic [NSLOT-1:0]         mask,
    input  logic [$clog2(NSLOT)-1:0] best_idx,
    input  logic                     best_vld,
    input  logic [$clog2(NSLOT)-1:0] sec_idx,
    input  logic                     sec_vld,
    output logic [NSLOT*SW-1:0]      routed
);

    localparam int IW = $clog2(NSLOT);

    logic [SW-1:0] best_sample;
    logic [SW-1:0] sec_sample;

    // Fetch the two chosen voices; silence when absent.
    always_comb begin
        best_sample = best_vld ? frame_flat[best_idx*SW +: SW] : '0;
        sec_sample  = sec_vld  ? frame_flat[sec_idx*SW +: SW]  : '0;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [IW-1:0] SID = IW'(s);
        // Choose what slot s hears.
        always_comb begin
            if (!mask[s]) begin
                routed[s*SW +: SW] = '0;
            end else if (best_vld && (best_idx == SID)) begin
                routed[s*SW +: SW] = sec_sample;
            end else begin
                routed[s*SW +: SW] = best_sample;
            end
        end
    end

endmodule

// File: rtl/conf_talker_select.sv
// Top of the loudest-talker conference selector.
// Latches a frame on each strobe, ranks it during the next interval and
// routes it on the following strobe.
// Assumes: strobes are at least NSLOT+1 cycles apart and one cycle long.
module conf_talker_select #(
    parameter int NSLOT = 32,
    parameter int SW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSLOT*SW-1:0]      in_frame,
    input  logic [NSLOT-1:0]         in_mask,
    input  logic                     in_frame_vld,
    output logic [NSLOT*SW-1:0]      out_frame,
    output logic                     out_vld,
    output logic [$clog2(NSLOT)-1:0] sel_first,
    output logic [$clog2(NSLOT)-1:0] sel_second,
    output logic                     sel_second_vld
);

    localparam int IW = $clog2(NSLOT);

    logic [NSLOT*SW-1:0] rx_frame;
    logic [NSLOT-1:0]    rx_mask;
    logic                rx_full;
    logic [IW-1:0]       rk_best_idx;
    logic                rk_best_vld;
    logic [IW-1:0]       rk_sec_idx;
    logic                rk_sec_vld;
    logic                rk_done;
    logic [NSLOT*SW-1:0] routed;

    conf_rank_scan #(.NSLOT(NSLOT), .SW(SW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (in_frame_vld),
        .frame_flat (rx_frame),
        .mask       (rx_mask),
        .best_idx   (rk_best_idx),
        .best_vld   (rk_best_vld),
        .sec_idx    (rk_sec_idx),
        .sec_vld    (rk_sec_vld),
        .done       (rk_done)
    );

    conf_frame_route #(.NSLOT(NSLOT), .SW(SW)) u_route (
        .frame_flat (rx_frame),
        .mask       (rx_mask),
        .best_idx   (rk_best_idx),
        .best_vld   (rk_best_vld),
        .sec_idx    (rk_sec_idx),
        .sec_vld    (rk_sec_vld),
        .routed     (routed)
    );

    // Latch the arriving frame for ranking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_frame <= '0;
            rx_mask  <= '0;
            rx_full  <= 1'b0;
        end else if (in_frame_vld) begin
            rx_frame <= in_frame;
            rx_mask  <= in_mask;
            rx_full  <= 1'b1;
        end
    end

    // Publish the ranked previous frame on the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_frame      <= '0;
            out_vld        <= 1'b0;
            sel_first      <= '0;
            sel_second     <= '0;
            sel_second_vld <= 1'b0;
        end else begin
            out_vld <= 1'b0;
            if (in_frame_vld && rx_full && rk_done) begin
                out_frame <= routed;
                out_vld   <= 1'b1;
                if (rk_best_vld) begin
                    sel_first      <= rk_best_idx;
                    sel_second     <= rk_sec_vld ? rk_sec_idx : '0;
                    sel_second_vld <= rk_sec_vld;
                end
            end
        end
    end

endmodule

// File: rtl/conf_talker_select_chk.sv
// Assertion checker for conf_talker_select, attached by bind below.
// Keeps its own copy of the last two latched frames and a strobe gap count.
module conf_talker_select_chk #(
    parameter int NSLOT = 32,
    parameter int SW    = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NSLOT*SW-1:0]      in_frame,
    input logic                     in_frame_vld,
    input logic [NSLOT*SW-1:0]      out_frame,
    input logic                     out_vld,
    input logic [$clog2(NSLOT)-1:0] sel_first,
    input logic [$clog2(NSLOT)-1:0] sel_second,
    input logic                     sel_second_vld
);

    localparam int CW = $clog2(NSLOT) + 2;
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [NSLOT*SW-1:0] last_frame;
    logic [NSLOT*SW-1:0] prior_frame;
    logic [CW-1:0]       gap_cnt;
    logic                seen_strobe;

    // Record frames and the distance since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_frame  <= '0;
            prior_frame <= '0;
            gap_cnt     <= '0;
            seen_strobe <= 1'b0;
        end else if (in_frame_vld) begin
            prior_frame <= last_frame;
            last_frame  <= in_frame;
            gap_cnt     <= '0;
            seen_strobe <= 1'b1;
        end else if (gap_cnt != CNT_MAX) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_strobe_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_vld && seen_strobe) |-> (gap_cnt >= CW'(NSLOT)));

    assert_pulse_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_frame_vld));

    assert_frame_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(out_frame) && $stable(sel_first) && $stable(sel_second)));

    assert_pair_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_second_vld |-> (sel_first != sel_second));

    for (genvar s = 0; s < NSLOT; s++) begin : g_src
        // R3: each routed slot is silence or one of the two chosen voices.
        assert_slot_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> ((out_frame[s*SW +: SW] == '0) ||
                         (out_frame[s*SW +: SW] == prior_frame[sel_first*SW +: SW]) ||
                         (sel_second_vld &&
                          (out_frame[s*SW +: SW] == prior_frame[sel_second*SW +: SW]))));
    end

endmodule

bind conf_talker_select conf_talker_select_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_frame       (in_frame),
    .in_frame_vld   (in_frame_vld),
    .out_frame      (out_frame),
    .out_vld        (out_vld),
    .sel_first      (sel_first),
    .sel_second     (sel_second),
    .sel_second_vld (sel_second_vld)
);

// File: tb/tb_conf_talker_select.sv
// Directed bench for conf_talker_select: one task per scenario.
module tb_conf_talker_select;

    localparam int NSLOT = 32;
    localparam int SW    = 16;
    localparam int IW    = $clog2(NSLOT);
    localparam int GAP   = NSLOT + 4;

    logic                clk;
    logic                rst_n;
    logic [NSLOT*SW-1:0] in_frame;
    logic [NSLOT-1:0]    in_mask;
    logic                in_frame_vld;
    logic [NSLOT*SW-1:0] out_frame;
    logic                out_vld;
    logic [IW-1:0]       sel_first;
    logic [IW-1:0]       sel_second;
    logic                sel_second_vld;

    int checks;
    int errors;

    // Bench model state.
    logic signed [SW-1:0] cur_s  [NSLOT];
    logic [NSLOT-1:0]     cur_m;
    logic signed [SW-1:0] prev_s [NSLOT];
    logic [NSLOT-1:0]     prev_m;
    logic                 prev_has;
    logic [IW-1:0]        exp_first;
    logic [IW-1:0]        exp_second;
    logic                 exp_sec_vld;

    conf_talker_select #(.NSLOT(NSLOT), .SW(SW)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_frame       (in_frame),
        .in_mask        (in_mask),
        .in_frame_vld   (in_frame_vld),
        .out_frame      (out_frame),
        .out_vld        (out_vld),
        .sel_first      (sel_first),
        .sel_second     (sel_second),
        .sel_second_vld (sel_second_vld)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mag_of(input logic signed [SW-1:0] v);
        if (v == -32768) return 32767;
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

    task automatic clear_frame();
        for (int s = 0; s < NSLOT; s++) cur_s[s] = '0;
        cur_m = '0;
    endtask

    // Send cur_s/cur_m and check the routing of the previously sent frame.
    task automatic send_frame(input string req);
        int bi;
        int si;
        int bad;
        logic signed [SW-1:0] exp_slot;
        logic [NSLOT*SW-1:0] snap;
        bi = -1;
        si = -1;
        for (int s = 0; s < NSLOT; s++) begin
            if (prev_m[s]) begin
                if (bi < 0 || mag_of(prev_s[s]) > mag_of(prev_s[bi])) begin
                    si = bi;
                    bi = s;
                end else if (si < 0 || mag_of(prev_s[s]) > mag_of(prev_s[si])) begin
                    si = s;
                end
            end
        end
        @(negedge clk);
        for (int s = 0; s < NSLOT; s++) in_frame[s*SW +: SW] = cur_s[s];
        in_mask      = cur_m;
        in_frame_vld = 1'b1;
        @(negedge clk);
        in_frame_vld = 1'b0;
        check(out_vld == prev_has, req, "out_vld after strobe", out_vld, prev_has);
        if (prev_has) begin
            if (bi >= 0) begin
                exp_first   = IW'(bi);
                exp_second  = (si >= 0) ? IW'(si) : '0;
                exp_sec_vld = (si >= 0);
            end
            bad = 0;
            for (int s = 0; s < NSLOT; s++) begin
                if (!prev_m[s]) exp_slot = '0;
                else if (s == bi) exp_slot = (si >= 0) ? prev_s[si] : '0;
                else exp_slot = prev_s[bi];
                if ($signed(out_frame[s*SW +: SW]) != exp_slot) begin
                    bad++;
                    $display("FAIL %s slot %0d actual=%0d expected=%0d", req, s,
                             $signed(out_frame[s*SW +: SW]), exp_slot);
                end
            end
            checks++;
            if (bad != 0) errors++;
            check(sel_first == exp_first, req, "sel_first", sel_first, exp_first);
            check(sel_second == exp_second, req, "sel_second", sel_second, exp_second);
            check(sel_second_vld == exp_sec_vld, req, "sel_second_vld",
                  sel_second_vld, exp_sec_vld);
        end
        snap = out_frame;
        repeat (GAP) @(negedge clk);
        check(out_vld == 1'b0, "R8", "out_vld between strobes", out_vld, 0);
        check(out_frame == snap, "R8", "out_frame held", 0, 0);
        for (int s = 0; s < NSLOT; s++) prev_s[s] = cur_s[s];
        prev_m   = cur_m;
        prev_has = 1'b1;
    endtask

    // Zero-member frame used to flush a scenario's result.
    task automatic flush(input string req);
        clear_frame();
        for (int s = 0; s < NSLOT; s++) cur_s[s] = SW'(s * 11 + 3);
        send_frame(req);
    endtask

    task automatic t_reset_R9();
        check(out_vld == 1'b0, "R9", "out_vld reset", out_vld, 0);
        check(out_frame == '0, "R9", "out_frame reset", 0, 0);
        check(sel_first == '0 && sel_second == '0 && !sel_second_vld, "R9",
              "selection reset", sel_first, 0);
        clear_frame();
        cur_m   = 32'h0000_0003;
        cur_s[0] = 16'sd7;
        cur_s[1] = 16'sd9;
        send_frame("R9");
    endtask

    task automatic t_basic_R1_R3();
        clear_frame();
        cur_m = 32'h0000_000F;
        cur_s[0] = 16'sd100;
        cur_s[1] = -16'sd900;
        cur_s[2] = 16'sd300;
        cur_s[3] = 16'sd50;
        send_frame("R1");
        flush("R3");
    endtask

    task automatic t_nonmember_R4();
        clear_frame();
        cur_m = '0;
        cur_m[2] = 1'b1;
        cur_m[5] = 1'b1;
        cur_m[9] = 1'b1;
        cur_s[2] = -16'sd40;
        cur_s[5] = 16'sd200;
        cur_s[7] = 16'sd30000;
        cur_s[9] = 16'sd120;
        cur_s[0] = -16'sd25000;
        send_frame("R4");
        flush("R4");
    endtask

    task automatic t_saturate_R2();
        clear_frame();
        cur_m[3] = 1'b1;
        cur_m[5] = 1'b1;
        cur_m[8] = 1'b1;
        cur_s[3] = 16'sd32767;
        cur_s[5] = -16'sd32768;
        cur_s[8] = 16'sd10;
        send_frame("R2");
        flush("R2");
    endtask

    task automatic t_tie_R5();
        clear_frame();
        cur_m[20] = 1'b1;
        cur_m[10] = 1'b1;
        cur_m[4]  = 1'b1;
        cur_s[20] = 16'sd500;
        cur_s[10] = 16'sd500;
        cur_s[4]  = -16'sd500;
        send_frame("R5");
        flush("R5");
    endtask

    task automatic t_single_R6();
        clear_frame();
        cur_m[31] = 1'b1;
        cur_s[31] = 16'sd1234;
        cur_s[30] = 16'sd5000;
        send_frame("R6");
        flush("R6");
    endtask

    task automatic t_empty_R7();
        // exp_first/second/sec_vld are left as the R6 selection by the model.
        clear_frame();
        for (int s = 0; s < NSLOT; s++) cur_s[s] = SW'(1000 - s * 50);
        send_frame("R7");
        flush("R7");
        check(sel_first == 5'd31 && !sel_second_vld, "R7", "selection kept",
              sel_first, 31);
    endtask

    task automatic t_full_R3();
        clear_frame();
        cur_m = '1;
        for (int s = 0; s < NSLOT; s++) cur_s[s] = SW'((s * 37) % 101 - 50);
        send_frame("R3");
        flush("R3");
    endtask

    initial begin
        checks       = 0;
        errors       = 0;
        rst_n        = 1'b0;
        in_frame     = '0;
        in_mask      = '0;
        in_frame_vld = 1'b0;
        prev_has     = 1'b0;
        prev_m       = '0;
        exp_first    = '0;
        exp_second   = '0;
        exp_sec_vld  = 1'b0;
        for (int s = 0; s < NSLOT; s++) prev_s[s] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R9();
        t_basic_R1_R3();
        t_nonmember_R4();
        t_saturate_R2();
        t_tie_R5();
        t_single_R6();
        t_empty_R7();
        t_full_R3();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule